// File: doc/BRIEF.md
# Six-Channel DAC Settings Register Bank

This block stores the per-channel settings that a six-output digital-to-analog datapath needs: an attenuation value in quarter-decibel steps, a de-emphasis filter choice, and a two-bit selection of how converter input signals are mixed into the channel. Software reaches the bank through a simple synchronous register write port and a combinational read port. The decoded settings of every channel are driven continuously on flat output buses for the filter and mixer logic downstream.

Channel writes are steered by a six-bit selection mask that is held in its own register. A single write to the channel data address then updates every channel whose mask bit is set, which can be one channel, any pair or all six. A separate shared-feature address updates the even-numbered channels (2, 4 and 6) without looking at the mask. Only the volume field is copied. Those channels keep their de-emphasis and mix fields.

Top module: `dac_chan_regbank`

## Requirements
- R1: After reset every channel holds volume 0, de-emphasis code 0 and mix code 0, and the selection mask is 0. All output buses and every readback are then 0.
- R2: A write to address 0x10 loads wr_data[5:0] into the selection mask, where bit i stands for channel i+1. Reading address 0x10 returns the mask in bits 5:0 and zeros in bits 15:6.
- R3: A write to address 0x12 loads volume wr_data[7:0], de-emphasis wr_data[10:8] and mix wr_data[13:12] into every channel whose mask bit is set. The update is visible after that clock edge. Unselected channels keep their values.
- R4: A write to address 0x12 while the mask is 0 changes no channel.
- R5: A write to address 0x11 loads wr_data[7:0] into the volume of channels 2, 4 and 6, whatever the mask holds. Channels 1, 3 and 5 are unchanged.
- R6: A write to address 0x11 leaves the de-emphasis and mix fields of channels 2, 4 and 6 unchanged.
- R7: deemph_o carries codes 0 to 4 exactly as stored: off, 32 kHz, 44.1 kHz, 48 kHz and 96 kHz. Stored codes 5, 6 and 7 appear on deemph_o as 0, while readback still returns the stored code.
- R8: Reading address 0x20+i (i = 0..5) returns channel i+1 as {2'b00, mix, 1'b0, de-emphasis, volume}, that is mix at bits 13:12, de-emphasis at 10:8 and volume at 7:0. Bits 15:14 and 11 read 0 whatever was written there. Any other read address returns 0.
- R9: Channel i+1 drives vol_o[8i+7:8i], deemph_o[3i+2:3i] and mix_o[2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Combinational readback |
| vol_o | output | 48 | Volume per channel, 8 bits each |
| deemph_o | output | 18 | Decoded de-emphasis per channel, 3 bits each |
| mix_o | output | 12 | Mix selection per channel, 2 bits each |

## Verification
A mask bit that is lost or set in the wrong place shows up in the same cycle as a wrong channel word on rd_data. The decoded buses show it one edge after the channel write. If the shared write is steered to the wrong channels, or copies too many fields, an odd channel's volume changes, or an even channel's de-emphasis or mix changes. Both are visible straight after that edge. A decode that passes an unused de-emphasis code through shows as a mismatch between deemph_o and the readback of the same channel.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
    localparam int VOL_W  = 8;
    localparam int DE_W   = 3;
    localparam int MIX_W  = 2;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;

    localparam int VOL_LSB = 0;
    localparam int DE_LSB  = 8;
    localparam int MIX_LSB = 12;

    localparam logic [DE_W-1:0] DE_MAX_CODE = 3'd4;

    typedef struct packed {
        logic [MIX_W-1:0] mix;
        logic [DE_W-1:0]  de;
        logic [VOL_W-1:0] vol;
    } chan_t;

    function automatic logic [DE_W-1:0] de_decode(input logic [DE_W-1:0] code);
        return (code > DE_MAX_CODE) ? '0 : code;
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(input chan_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VOL_LSB +: VOL_W] = c.vol;
        w[DE_LSB  +: DE_W]  = c.de;
        w[MIX_LSB +: MIX_W] = c.mix;
        return w;
    endfunction
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
    import dac_regbank_pkg::*;
#(
    parameter int NCH = 6,
    parameter logic [ADDR_W-1:0] SEL_ADDR    = 8'h10,
    parameter logic [ADDR_W-1:0] SHARED_ADDR = 8'h11,
    parameter logic [ADDR_W-1:0] CHAN_ADDR   = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NCH-1:0]    wr_mask,
    output logic [NCH-1:0]    mask_q,
    output logic [NCH-1:0]    full_we,
    output logic [NCH-1:0]    shared_we
);
    logic [NCH-1:0] mask_d;
    logic           hit_sel, hit_shared, hit_chan;

    assign hit_sel    = wr_en && (wr_addr == SEL_ADDR);
    assign hit_shared = wr_en && (wr_addr == SHARED_ADDR);
    assign hit_chan   = wr_en && (wr_addr == CHAN_ADDR);

    always_comb begin
        mask_d = mask_q;
        if (hit_sel) mask_d = wr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign full_we = hit_chan ? mask_q : '0;

    for (genvar k = 0; k < NCH; k++) begin : g_shared
        if (k % 2 == 1) begin : g_even_chan
            assign shared_we[k] = hit_shared;
        end else begin : g_odd_chan
            assign shared_we[k] = 1'b0;
        end
    end

    // R4: with an empty mask no channel receives a full write
    a_r4_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (full_we == '0));
    // R2: a mask write is held from the next cycle
    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        hit_sel |=> (mask_q == $past(wr_mask)));
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg
    import dac_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  full_we,
    input  logic  shared_we,
    input  chan_t wr_val,
    output chan_t chan_q
);
    chan_t chan_d;

    always_comb begin
        chan_d = chan_q;
        if (full_we)        chan_d = wr_val;
        else if (shared_we) chan_d.vol = wr_val.vol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    // R3: a selected channel takes the whole written word
    a_r3_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        full_we |=> (chan_q == $past(wr_val)));
    // R6: a shared write keeps de-emphasis and mix
    a_r6_shared_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_we && !full_we) |=> ($stable(chan_q.de) && $stable(chan_q.mix)));
    // R4: with no strobe the channel holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && !shared_we) |=> $stable(chan_q));
endmodule

// File: rtl/dac_chan_regbank.sv
module dac_chan_regbank
    import dac_regbank_pkg::*;
#(
    parameter int NCH = 6,
    parameter logic [ADDR_W-1:0] SEL_ADDR    = 8'h10,
    parameter logic [ADDR_W-1:0] SHARED_ADDR = 8'h11,
    parameter logic [ADDR_W-1:0] CHAN_ADDR   = 8'h12,
    parameter logic [ADDR_W-1:0] RD_BASE     = 8'h20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NCH*VOL_W-1:0]   vol_o,
    output logic [NCH*DE_W-1:0]    deemph_o,
    output logic [NCH*MIX_W-1:0]   mix_o
);
    logic [NCH-1:0] mask_q, full_we, shared_we;
    chan_t          wr_val;
    chan_t          chans [NCH];
    logic           unused_wr_bits;

    assign wr_val.vol = wr_data[VOL_LSB +: VOL_W];
    assign wr_val.de  = wr_data[DE_LSB  +: DE_W];
    assign wr_val.mix = wr_data[MIX_LSB +: MIX_W];
    assign unused_wr_bits = ^{wr_data[DATA_W-1:MIX_LSB+MIX_W], wr_data[MIX_LSB-1:DE_LSB+DE_W]};

    dac_wr_decode #(
        .NCH(NCH), .SEL_ADDR(SEL_ADDR), .SHARED_ADDR(SHARED_ADDR), .CHAN_ADDR(CHAN_ADDR)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_mask(wr_data[NCH-1:0]), .mask_q(mask_q),
        .full_we(full_we), .shared_we(shared_we)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        dac_chan_reg u_reg (
            .clk(clk), .rst_n(rst_n),
            .full_we(full_we[k]), .shared_we(shared_we[k]),
            .wr_val(wr_val), .chan_q(chans[k])
        );
        assign vol_o[k*VOL_W +: VOL_W]    = chans[k].vol;
        assign deemph_o[k*DE_W +: DE_W]   = de_decode(chans[k].de);
        assign mix_o[k*MIX_W +: MIX_W]    = chans[k].mix;

        // R7: decoded de-emphasis never shows an unused code
        a_r7_deemph_range: assert property (@(posedge clk) disable iff (!rst_n)
            deemph_o[k*DE_W +: DE_W] <= DE_MAX_CODE);
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == SEL_ADDR) rd_data[NCH-1:0] = mask_q;
        for (int k = 0; k < NCH; k++) begin
            if (rd_addr == ADDR_W'(RD_BASE + k)) rd_data = pack_word(chans[k]);
        end
    end

    // R8: reserved readback bits stay zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DATA_W-1:MIX_LSB+MIX_W] == '0) && (rd_data[MIX_LSB-1:DE_LSB+DE_W] == '0));
endmodule

// File: tb/dac_chan_regbank_test.sv
module dac_chan_regbank_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic [7:0]  rd_addr = 0;
    logic [15:0] rd_data;
    logic [47:0] vol_o;
    logic [17:0] deemph_o;
    logic [11:0] mix_o;

    int total = 0;
    int bad = 0;
    logic [15:0] model [6];
    logic [5:0]  model_mask;

    always #10 clk = ~clk;

    dac_chan_regbank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vol_o(vol_o), .deemph_o(deemph_o), .mix_o(mix_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // full model comparison: readback (R8) and decoded outputs (R7, R9)
    task automatic check_all(input string tag);
        for (int i = 0; i < 6; i++) begin
            logic [2:0] de;
            rd_addr = 8'h20 + 8'(i);
            #1;
            check({tag, " R8 readback"}, rd_data, {16'h0, model[i]});
            de = model[i][10:8];
            check({tag, " R9 vol"}, vol_o[i*8 +: 8], model[i][7:0]);
            check({tag, " R7 deemph"}, deemph_o[i*3 +: 3], (de > 3'd4) ? 3'd0 : de);
            check({tag, " R9 mix"}, mix_o[i*2 +: 2], model[i][13:12]);
        end
        rd_addr = 8'h10;
        #1;
        check({tag, " R2 mask readback"}, rd_data, {10'h0, model_mask});
    endtask

    task automatic set_mask(input logic [15:0] d);
        do_write(8'h10, d);
        model_mask = d[5:0];
    endtask

    task automatic chan_write(input logic [15:0] d);
        do_write(8'h12, d);
        for (int i = 0; i < 6; i++)
            if (model_mask[i]) model[i] = d & 16'h37FF;
    endtask

    task automatic shared_write(input logic [15:0] d);
        do_write(8'h11, d);
        for (int i = 1; i < 6; i += 2) model[i][7:0] = d[7:0];
    endtask

    task automatic t_reset;
        for (int i = 0; i < 6; i++) model[i] = 0;
        model_mask = 0;
        check_all("R1 reset");
        check("R1 vol bus", vol_o, 0);
    endtask

    task automatic t_single;
        set_mask(16'hFFC1);
        check_all("R2 mask high bits ignored");
        chan_write(16'h1234);
        check_all("R3 channel 1 only");
    endtask

    task automatic t_pair_all;
        set_mask(16'h000A);
        chan_write(16'hF3A5);
        check_all("R3 channels 2 and 4, reserved bits dropped");
        set_mask(16'h003F);
        chan_write(16'h2177);
        check_all("R3 all channels");
    endtask

    task automatic t_empty;
        set_mask(16'h0000);
        chan_write(16'h3FFF);
        check_all("R4 empty mask");
    endtask

    task automatic t_shared;
        set_mask(16'h0015);
        chan_write(16'h1340);
        set_mask(16'h002A);
        chan_write(16'h2211);
        set_mask(16'h0001);
        shared_write(16'h37C8);
        check_all("R5 R6 shared write to even channels");
        set_mask(16'h0000);
        shared_write(16'h0055);
        check_all("R5 shared write ignores empty mask");
    endtask

    task automatic t_deemph;
        for (int c = 0; c < 8; c++) begin
            set_mask(16'h0001 << (c % 6));
            chan_write(16'(c << 8) | 16'h0003);
            check_all("R7 deemph code sweep");
        end
    endtask

    task automatic t_bad_addr;
        rd_addr = 8'h26;
        #1;
        check("R8 unknown read address", rd_data, 0);
        rd_addr = 8'h11;
        #1;
        check("R8 shared address reads zero", rd_data, 0);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_single;
        t_pair_all;
        t_empty;
        t_shared;
        t_deemph;
        t_bad_addr;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule